// File: doc/BRIEF.md
# Zero-Address Stack Execution Unit

This block executes a stream of zero-address instructions. Each instruction arrives on a valid/ready handshake with a 2-bit opcode and a 16-bit byte address. The address only matters for the two memory instructions. A push copies a byte from the data memory onto an internal operand stack. A pop stores the top of the stack into the data memory and removes it. Add and multiply take no operands. Each one consumes the top entry and the entry beneath it, and leaves the result as the new top.

The unit contains the operand stack, its depth counter, a small ALU and a synchronous single-port byte memory. A preload port lets the surrounding logic place bytes in that memory. An instruction that would drop below the bottom of the stack, or grow it past its last slot, is refused: the stack stays as it was and a one-cycle fault flag is raised.

An expression such as (a+b)*c is run as the instruction string push a, push b, add, push c, multiply, pop d. At the end the result sits at d and the stack is back at its starting depth.

Top module: `stk_exec_unit`

## Requirements
- R1: After reset, depth is 0, `stk_empty` is 1, `stk_full` is 0, `tos_data` is 0, both fault flags are 0 and `in_ready` is 1.
- R2: Opcode 00 is push. An accepted push on a non-full stack reads the byte at `in_addr`. `in_ready` is 0 in the cycle after acceptance. After the second rising edge the byte is on top and depth has grown by one.
- R3: Opcode 01 is pop. An accepted pop on a non-empty stack writes the top byte to `in_addr` and lowers depth by one at the accepting edge. A later push of that address returns the byte.
- R4: Opcode 10 is add. With at least two entries, the top and the entry beneath it are replaced by their sum modulo 256. Depth drops by one at the accepting edge.
- R5: Opcode 11 is multiply. It behaves like add but leaves the low 8 bits of the product.
- R6: A pop on an empty stack, or an add or multiply with fewer than two entries, raises `udf_flag` for exactly the one cycle after acceptance. Depth, top and the data memory are left unchanged.
- R7: A push on a full stack raises `ovf_flag` for the one cycle after acceptance. It reads no memory, leaves the stack unchanged and does not lower `in_ready`.
- R8: The string push a, push b, add, push c, multiply, pop d leaves ((a+b)*c) mod 256 at d and the stack at its starting depth.
- R9: While `ld_we` is 1, `in_ready` is 0 and `ld_data` is written to `ld_addr` at the rising edge.
- R10: The memory holds 2^MEM_AW bytes (1024 by default). Address bits at and above MEM_AW are ignored, so 0x0401 and 0x0001 name the same byte.
- R11: The stack has 256 slots. `stk_full` is 1 exactly when depth is 256, and depth never exceeds 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Unit can take an instruction this cycle |
| in_op | input | 2 | Opcode: 00 push, 01 pop, 10 add, 11 multiply |
| in_addr | input | 16 | Byte address for push and pop |
| ld_we | input | 1 | Preload write strobe into the data memory |
| ld_addr | input | 16 | Preload byte address |
| ld_data | input | 8 | Preload byte |
| tos_data | output | 8 | Current top of stack, 0 when empty |
| depth | output | 9 | Number of stack entries, 0 to 256 |
| stk_empty | output | 1 | Depth is 0 |
| stk_full | output | 1 | Depth is 256 |
| ovf_flag | output | 1 | One-cycle pulse after a refused push |
| udf_flag | output | 1 | One-cycle pulse after a refused pop or arithmetic instruction |

## Verification
Pop, add, multiply, both fault pulses and preload writes all take effect at the single rising edge that accepts them. A push needs a second edge, because the memory read is registered, and `in_ready` stays low in the cycle between. The bench reference model advances its state just after the edge where each of these results is due. It compares depth, top, the empty and full outputs, ready and both flags at every falling edge, so a result that arrives one cycle early or late shows up as a miscompare. Bytes stored by pop are checked end to end by pushing the same address back later.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    OP_PUSH = 2'b00,
    OP_POP  = 2'b01,
    OP_ADD  = 2'b10,
    OP_MUL  = 2'b11
  } stk_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } stk_state_e;
endpackage

// File: rtl/stk_alu.sv
module stk_alu #(
  parameter int W = 8
) (
  input  logic         sel_mul,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] res
);
  // Sum wraps modulo 2^W.
  function automatic logic [W-1:0] f_sum(input logic [W-1:0] a, input logic [W-1:0] b);
    return a + b;
  endfunction

  // Full product, low W bits kept.
  function automatic logic [W-1:0] f_prod(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [2*W-1:0] p;
    p = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    return p[W-1:0];
  endfunction

  assign res = sel_mul ? f_prod(opa, opb) : f_sum(opa, opb);
endmodule

// File: rtl/stk_regfile.sv
module stk_regfile #(
  parameter int W     = 8,
  parameter int DEPTH = 256
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push_en,
  input  logic [W-1:0]               push_val,
  input  logic                       shrink_en,
  input  logic                       repl_en,
  input  logic [W-1:0]               repl_val,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic [W-1:0]               top_val,
  output logic [W-1:0]               under_val
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [CW-1:0] count_q;
  logic [AW-1:0] top_idx, under_idx, wr_idx;
  logic          wr_en;
  logic [W-1:0]  wr_val;
  logic [W-1:0]  slot_rd [DEPTH];

  assign top_idx   = count_q[AW-1:0] - AW'(1);
  assign under_idx = count_q[AW-1:0] - AW'(2);

  // A push lands one above the top; an arithmetic result lands under the top.
  always_comb begin
    wr_en  = push_en | repl_en;
    wr_idx = push_en ? count_q[AW-1:0] : under_idx;
    wr_val = push_en ? push_val : repl_val;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [W-1:0] cell_q;
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == AW'(g))) cell_q <= wr_val;
    end
    assign slot_rd[g] = cell_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     count_q <= '0;
    else if (push_en)               count_q <= count_q + CW'(1);
    else if (shrink_en || repl_en)  count_q <= count_q - CW'(1);
  end

  assign count     = count_q;
  assign top_val   = (count_q != '0)      ? slot_rd[top_idx]   : '0;
  assign under_val = (count_q >= CW'(2))  ? slot_rd[under_idx] : '0;
endmodule

// File: rtl/stk_dmem.sv
module stk_dmem #(
  parameter int W      = 8,
  parameter int ADDR_W = 16,
  parameter int MEM_AW = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata
);
  localparam int WORDS = 2**MEM_AW;

  logic [W-1:0]      store [WORDS];
  logic [MEM_AW-1:0] idx;
  logic              unused_hi;

  assign idx = addr[MEM_AW-1:0];

  if (ADDR_W > MEM_AW) begin : g_alias
    assign unused_hi = ^addr[ADDR_W-1:MEM_AW];
  end else begin : g_exact
    assign unused_hi = 1'b0;
  end

  // One port: a write takes the cycle, otherwise the addressed byte is read.
  always_ff @(posedge clk) begin
    if (we) store[idx] <= wdata;
    else    rdata      <= store[idx];
  end
endmodule

// File: rtl/stk_exec_unit.sv
module stk_exec_unit #(
  parameter int W           = 8,
  parameter int STACK_DEPTH = 256,
  parameter int ADDR_W      = 16,
  parameter int MEM_AW      = 10
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             in_valid,
  output logic                             in_ready,
  input  logic [1:0]                       in_op,
  input  logic [ADDR_W-1:0]                in_addr,
  input  logic                             ld_we,
  input  logic [ADDR_W-1:0]                ld_addr,
  input  logic [W-1:0]                     ld_data,
  output logic [W-1:0]                     tos_data,
  output logic [$clog2(STACK_DEPTH+1)-1:0] depth,
  output logic                             stk_empty,
  output logic                             stk_full,
  output logic                             ovf_flag,
  output logic                             udf_flag
);
  import stk_pkg::*;
  localparam int CW = $clog2(STACK_DEPTH+1);

  stk_state_e    state_q;
  stk_op_e       op;
  logic          acc, is_push, is_pop, is_arith, has_two;
  logic          ev_push_start, ev_push_done, ev_pop, ev_arith, ev_ovf, ev_udf;
  logic [CW-1:0] count;
  logic [W-1:0]  top_val, under_val, alu_res, mem_rdata, mem_wdata;
  logic          mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic          ovf_q, udf_q;

  assign op       = stk_op_e'(in_op);
  assign in_ready = (state_q == ST_IDLE) && !ld_we;
  assign acc      = in_valid && in_ready;
  assign is_push  = acc && (op == OP_PUSH);
  assign is_pop   = acc && (op == OP_POP);
  assign is_arith = acc && ((op == OP_ADD) || (op == OP_MUL));
  assign has_two  = count >= CW'(2);

  assign stk_empty = (count == '0);
  assign stk_full  = (count == CW'(STACK_DEPTH));

  // Named internal events, shared with the bound checker.
  assign ev_push_start = is_push && !stk_full;
  assign ev_push_done  = (state_q == ST_FILL);
  assign ev_pop        = is_pop && !stk_empty;
  assign ev_arith      = is_arith && has_two;
  assign ev_ovf        = is_push && stk_full;
  assign ev_udf        = (is_pop && stk_empty) || (is_arith && !has_two);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ovf_q   <= 1'b0;
      udf_q   <= 1'b0;
    end else begin
      state_q <= ev_push_start ? ST_FILL : ST_IDLE;
      ovf_q   <= ev_ovf;
      udf_q   <= ev_udf;
    end
  end

  // Memory port: preload has the port whenever it writes (ready is low then).
  always_comb begin
    mem_we    = ld_we || ev_pop;
    mem_addr  = ld_we ? ld_addr : in_addr;
    mem_wdata = ld_we ? ld_data : top_val;
  end

  stk_dmem #(.W(W), .ADDR_W(ADDR_W), .MEM_AW(MEM_AW)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .addr  (mem_addr),
    .wdata (mem_wdata),
    .rdata (mem_rdata)
  );

  stk_alu #(.W(W)) u_alu (
    .sel_mul (in_op[0]),
    .opa     (under_val),
    .opb     (top_val),
    .res     (alu_res)
  );

  stk_regfile #(.W(W), .DEPTH(STACK_DEPTH)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_en   (ev_push_done),
    .push_val  (mem_rdata),
    .shrink_en (ev_pop),
    .repl_en   (ev_arith),
    .repl_val  (alu_res),
    .count     (count),
    .top_val   (top_val),
    .under_val (under_val)
  );

  assign tos_data = top_val;
  assign depth    = count;
  assign ovf_flag = ovf_q;
  assign udf_flag = udf_q;
endmodule

// File: rtl/stk_exec_chk.sv
module stk_exec_chk #(
  parameter int W           = 8,
  parameter int STACK_DEPTH = 256
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             in_ready,
  input logic [$clog2(STACK_DEPTH+1)-1:0] depth,
  input logic [W-1:0]                     tos_data,
  input logic                             stk_full,
  input logic                             ovf_flag,
  input logic                             udf_flag,
  input logic                             ev_push_start,
  input logic                             ev_push_done,
  input logic                             ev_pop,
  input logic                             ev_arith,
  input logic                             ev_ovf,
  input logic                             ev_udf
);
  localparam int CW = $clog2(STACK_DEPTH+1);

  AST_PUSH_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    ev_push_start |=> (!in_ready && $stable(depth)));                 // R2
  AST_PUSH_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    ev_push_done |=> (depth == $past(depth) + CW'(1)));               // R2
  AST_POP_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pop |=> (depth == $past(depth) - CW'(1)));                     // R3
  AST_ARITH_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
    ev_arith |=> (depth == $past(depth) - CW'(1)));                   // R4
  AST_UNDERFLOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ev_udf |=> (udf_flag && $stable(depth) && $stable(tos_data)));    // R6
  AST_OVERFLOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ovf |=> (ovf_flag && stk_full && $stable(depth)));             // R7
  AST_NO_DOUBLE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_flag && udf_flag));                                         // R6
  AST_DEPTH_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= CW'(STACK_DEPTH));                                       // R11
endmodule

bind stk_exec_unit stk_exec_chk #(.W(W), .STACK_DEPTH(STACK_DEPTH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_ready      (in_ready),
  .depth         (depth),
  .tos_data      (tos_data),
  .stk_full      (stk_full),
  .ovf_flag      (ovf_flag),
  .udf_flag      (udf_flag),
  .ev_push_start (ev_push_start),
  .ev_push_done  (ev_push_done),
  .ev_pop        (ev_pop),
  .ev_arith      (ev_arith),
  .ev_ovf        (ev_ovf),
  .ev_udf        (ev_udf)
);

// File: tb/sim_stk_exec_unit.sv
`timescale 1ns/1ps
module sim_stk_exec_unit;
  localparam int DEPTH = 256;
  localparam int WORDS = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_op = 2'b00;
  logic [15:0] in_addr = '0;
  logic        ld_we = 1'b0;
  logic [15:0] ld_addr = '0;
  logic [7:0]  ld_data = '0;
  logic [7:0]  tos_data;
  logic [8:0]  depth;
  logic        stk_empty, stk_full, ovf_flag, udf_flag;

  always #4 clk = ~clk;  // 125 MHz

  stk_exec_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_addr(in_addr), .ld_we(ld_we), .ld_addr(ld_addr),
    .ld_data(ld_data), .tos_data(tos_data), .depth(depth),
    .stk_empty(stk_empty), .stk_full(stk_full),
    .ovf_flag(ovf_flag), .udf_flag(udf_flag)
  );

  // Behavioural reference state.
  logic [7:0] m_stk [$];
  logic [7:0] m_mem [WORDS];
  logic       m_ready = 1'b1;
  logic       m_ovf = 1'b0;
  logic       m_udf = 1'b0;
  logic       chk_on = 1'b0;
  logic       seen_ovf, seen_udf;
  string      cur_req = "R1";
  int         n_vec = 0;
  int         n_fail = 0;

  function automatic logic [7:0] m_top();
    return (m_stk.size() != 0) ? m_stk[$] : 8'h00;
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model.
  always @(negedge clk) begin
    if (chk_on) begin
      logic bad;
      bad = 1'b0;
      n_vec++;
      if (int'(depth) != m_stk.size()) begin
        bad = 1'b1; $display("FAIL %s depth: actual %0d expected %0d", cur_req, depth, m_stk.size());
      end
      if (tos_data != m_top()) begin
        bad = 1'b1; $display("FAIL %s top: actual %0h expected %0h", cur_req, tos_data, m_top());
      end
      if (stk_empty != (m_stk.size() == 0)) begin
        bad = 1'b1; $display("FAIL %s empty: actual %0b expected %0b", cur_req, stk_empty, m_stk.size() == 0);
      end
      if (stk_full != (m_stk.size() == DEPTH)) begin
        bad = 1'b1; $display("FAIL R11 full: actual %0b expected %0b", stk_full, m_stk.size() == DEPTH);
      end
      if (in_ready != m_ready) begin
        bad = 1'b1; $display("FAIL %s ready: actual %0b expected %0b", cur_req, in_ready, m_ready);
      end
      if (ovf_flag != m_ovf) begin
        bad = 1'b1; $display("FAIL %s ovf: actual %0b expected %0b", cur_req, ovf_flag, m_ovf);
      end
      if (udf_flag != m_udf) begin
        bad = 1'b1; $display("FAIL %s udf: actual %0b expected %0b", cur_req, udf_flag, m_udf);
      end
      if (bad) n_fail++;
    end
  end

  task automatic preload(input logic [15:0] a, input logic [7:0] d);
    ld_we = 1'b1; ld_addr = a; ld_data = d; m_ready = 1'b0;
    @(posedge clk); #1;
    ld_we = 1'b0; m_ready = 1'b1; m_mem[a[9:0]] = d;
  endtask

  // Offer one instruction, advance the model at each due edge, then one idle cycle.
  task automatic issue(input logic [1:0] op, input logic [15:0] a);
    logic [7:0] t, u, pend;
    logic [15:0] p;
    in_valid = 1'b1; in_op = op; in_addr = a;
    @(posedge clk); #1;
    in_valid = 1'b0;
    case (op)
      2'b00: if (m_stk.size() == DEPTH) m_ovf = 1'b1;
             else begin pend = m_mem[a[9:0]]; m_ready = 1'b0; end
      2'b01: if (m_stk.size() == 0) m_udf = 1'b1;
             else m_mem[a[9:0]] = m_stk.pop_back();
      default:
        if (m_stk.size() < 2) m_udf = 1'b1;
        else begin
          t = m_stk.pop_back(); u = m_stk.pop_back();
          p = 16'(u) * 16'(t);
          m_stk.push_back(op == 2'b10 ? u + t : p[7:0]);
        end
    endcase
    @(negedge clk);
    seen_ovf = ovf_flag; seen_udf = udf_flag;
    if (!m_ready) begin
      @(posedge clk); #1;
      m_stk.push_back(pend); m_ready = 1'b1;
    end
    @(posedge clk); #1;
    m_ovf = 1'b0; m_udf = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk_on = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", depth, 0); chk("R1", in_ready, 1); chk("R1", stk_empty, 1);
    chk("R1", stk_full, 0); chk("R1", tos_data, 0); chk("R1", ovf_flag | udf_flag, 0);
    @(posedge clk); #1;

    cur_req = "R9";
    preload(16'h0000, 8'h11); preload(16'h0001, 8'hF0); preload(16'h0002, 8'h20);
    preload(16'h0003, 8'h13); preload(16'h0004, 8'h0B); preload(16'h0005, 8'h07);
    preload(16'h0030, 8'h5A);

    cur_req = "R2";
    issue(2'b00, 16'h0000);
    chk("R2", tos_data, 8'h11); chk("R2", depth, 1);

    cur_req = "R3";
    issue(2'b01, 16'h0020); chk("R3", depth, 0);
    issue(2'b00, 16'h0020); chk("R3", tos_data, 8'h11);
    issue(2'b01, 16'h0021);

    cur_req = "R4";
    issue(2'b00, 16'h0001); issue(2'b00, 16'h0002); issue(2'b10, 16'h0000);
    chk("R4", tos_data, 8'h10); chk("R4", depth, 1);
    issue(2'b01, 16'h0022);

    cur_req = "R5";
    issue(2'b00, 16'h0003); issue(2'b00, 16'h0004); issue(2'b11, 16'h0000);
    chk("R5", tos_data, 8'hD1);
    issue(2'b00, 16'h0001); issue(2'b00, 16'h0002); issue(2'b11, 16'h0000);
    chk("R5", tos_data, 8'h00); chk("R5", depth, 2);
    issue(2'b01, 16'h0023); issue(2'b01, 16'h0024);

    cur_req = "R8";
    issue(2'b00, 16'h0004); issue(2'b00, 16'h0005); issue(2'b10, 16'h0000);
    issue(2'b00, 16'h0002); issue(2'b11, 16'h0000); issue(2'b01, 16'h0100);
    chk("R8", depth, 0);
    issue(2'b00, 16'h0100); chk("R8", tos_data, 8'h40);
    issue(2'b01, 16'h0025);

    cur_req = "R6";
    issue(2'b01, 16'h0030);
    chk("R6", seen_udf, 1); chk("R6", depth, 0);
    issue(2'b00, 16'h0030); chk("R6", tos_data, 8'h5A);
    issue(2'b10, 16'h0000); chk("R6", seen_udf, 1); chk("R6", tos_data, 8'h5A);
    issue(2'b11, 16'h0000); chk("R6", seen_udf, 1); chk("R6", depth, 1);
    issue(2'b01, 16'h0031);

    cur_req = "R10";
    issue(2'b00, 16'h0401); chk("R10", tos_data, 8'hF0);
    issue(2'b01, 16'h0026);

    cur_req = "R11";
    for (int i = 0; i < DEPTH; i++) issue(2'b00, 16'h0000);
    chk("R11", stk_full, 1); chk("R11", depth, 256);
    cur_req = "R7";
    issue(2'b00, 16'h0001);
    chk("R7", seen_ovf, 1); chk("R7", depth, 256); chk("R7", tos_data, 8'h11);

    chk_on = 1'b0;
    finish_run();
  end
endmodule